// File: doc/BRIEF.md
# Instruction Prefix and Operand-Select Front End

This block sits at the front of a byte-coded 16-bit processor. It holds a one-byte prefetch pipe: the opcode being executed is always the byte already in that pipe. On each execute step the next program byte, already read by the surrounding logic from the current program address, is written into the pipe. The block combines the held opcode with two page-mode bits into a 10-bit decode index. An external opcode table uses that index, and it returns an instruction kind, a register field and flag-update enables for the current step.

Prefix instructions change only the front-end state. They can select one of three alternate opcode pages, redirect the destination pointer, redirect the source pointer, or bind both pointers to one register and raise a bind flag. That state lasts until the next ordinary instruction completes. At that point the page bits and the bind flag clear and both pointers return to register 0.

Ordinary instructions can also update the condition bits: zero and sign come from the 16-bit result, while carry and overflow are supplied by the datapath. When an ordinary instruction writes register 14 as its destination, the block asks for a ROM-buffer refresh.

Top module: `pfx_decode_front`

## Requirements
- R1: After a synchronous active-high reset, the following are all zero: the pipe byte, the decode index, both register selects, the whole 16-bit status word and `rom_refresh`.
- R2: On a cycle with `step` high, the value on `fetch_byte` becomes the new pipe byte, which shows on `dec_index[7:0]` after the edge. A cycle with `pipe_fill` high and `step` low loads the pipe the same way, and leaves every other output unchanged.
- R3: `dec_index` is {page-high bit, page-low bit, pipe byte}. The page-low bit is `status[8]` and the page-high bit is `status[9]`. Kind 1 sets the page bits to low=1/high=0, kind 2 sets them to low=0/high=1, and kind 3 sets both.
- R4: Kind 4 loads `op_reg` into the destination select only. Kind 5 loads `op_reg` into the source select only.
- R5: Kind 6 loads `op_reg` into both selects and sets the bind flag at `status[12]`.
- R6: A prefix (kinds 1 to 6) changes only its own state. Earlier prefix state and the condition bits are kept, whatever the flag enables are.
- R7: An ordinary step (kind 0, or kind 7, which is reserved and treated as ordinary) clears both page bits and the bind flag, and it sets both selects to register 0.
- R8: On an ordinary step with `upd_zs` high, `status[1]` becomes 1 exactly when `result` is 0, and `status[3]` takes `result[15]`. With `upd_zs` low, both bits are held.
- R9: On an ordinary step with `upd_cv` high, `status[2]` takes `carry_in` and `status[4]` takes `ovf_in`. With `upd_cv` low, both bits are held.
- R10: `rom_refresh` is high for the single cycle after an ordinary step that has `wr_en` high while the destination select is 14. It is low at all other times.
- R11: While `step` is low (and `pipe_fill` is low), every output holds its value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Execute the instruction in the pipe and load the next byte |
| pipe_fill | input | 1 | Load the pipe without executing |
| fetch_byte | input | 8 | Next program byte |
| op_kind | input | 3 | Kind of the current instruction (0 ordinary, 1-3 page, 4 dest, 5 source, 6 bind, 7 reserved) |
| op_reg | input | 4 | Register field of the current instruction |
| result | input | 16 | Result of the current ordinary instruction |
| upd_zs | input | 1 | Update zero and sign bits |
| upd_cv | input | 1 | Update carry and overflow bits |
| carry_in | input | 1 | Carry produced by the datapath |
| ovf_in | input | 1 | Overflow produced by the datapath |
| wr_en | input | 1 | Current ordinary instruction writes its destination |
| dec_index | output | 10 | Decode index {page-high, page-low, opcode} |
| src_sel | output | 4 | Source register pointer |
| dst_sel | output | 4 | Destination register pointer |
| status | output | 16 | Status word (bits 1 Z, 2 C, 3 S, 4 V, 8 page-low, 9 page-high, 12 bind) |
| rom_refresh | output | 1 | Request to reload the ROM buffer from the register-14 address |

## Verification
Wrong page bits appear in `dec_index[9:8]` right after the edge, so every following opcode is decoded from the wrong table. A page bit or pointer that is left set shows up at the first ordinary step, because the selects and the status word fail to return to zero one cycle later. A lost or extra refresh shows on `rom_refresh` in the cycle after the writing step. Condition bits that are wrongly held or wrongly updated appear in `status` in the cycle after the step.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef enum logic [2:0] {
        K_PLAIN = 3'd0,
        K_PAGE1 = 3'd1,
        K_PAGE2 = 3'd2,
        K_PAGE3 = 3'd3,
        K_DST   = 3'd4,
        K_SRC   = 3'd5,
        K_BIND  = 3'd6,
        K_RSVD  = 3'd7
    } op_kind_e;

    localparam int ST_W    = 16;
    localparam int ST_Z    = 1;
    localparam int ST_C    = 2;
    localparam int ST_S    = 3;
    localparam int ST_V    = 4;
    localparam int ST_PLO  = 8;
    localparam int ST_PHI  = 9;
    localparam int ST_BIND = 12;

    typedef struct packed {
        logic v;
        logic s;
        logic c;
        logic z;
    } cond_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } page_t;

    function automatic logic is_plain(op_kind_e k);
        return (k == K_PLAIN) || (k == K_RSVD);
    endfunction

    function automatic page_t page_of(op_kind_e k);
        page_t p;
        p.lo = (k == K_PAGE1) || (k == K_PAGE3);
        p.hi = (k == K_PAGE2) || (k == K_PAGE3);
        return p;
    endfunction

endpackage

// File: rtl/pfx_pipe.sv
module pfx_pipe #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= din;
    end
endmodule

// File: rtl/pfx_mode.sv
module pfx_mode
    import pfx_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  op_kind_e         kind,
    input  logic [SEL_W-1:0] reg_in,
    output page_t            page,
    output logic             bind_f,
    output logic [SEL_W-1:0] src,
    output logic [SEL_W-1:0] dst
);
    always_ff @(posedge clk) begin
        if (rst) begin
            page   <= '0;
            bind_f <= 1'b0;
            src    <= '0;
            dst    <= '0;
        end else if (step) begin
            case (kind)
                K_PAGE1, K_PAGE2, K_PAGE3: page <= page_of(kind);
                K_DST:  dst <= reg_in;
                K_SRC:  src <= reg_in;
                K_BIND: begin
                    bind_f <= 1'b1;
                    src    <= reg_in;
                    dst    <= reg_in;
                end
                default: begin
                    page   <= '0;
                    bind_f <= 1'b0;
                    src    <= '0;
                    dst    <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pfx_cond.sv
module pfx_cond
    import pfx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_zs,
    input  logic              upd_cv,
    input  logic [DATA_W-1:0] res,
    input  logic              cy,
    input  logic              ov,
    output cond_t             cond
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cond <= '0;
        end else begin
            if (upd_zs) begin
                cond.z <= (res == '0);
                cond.s <= res[DATA_W-1];
            end
            if (upd_cv) begin
                cond.c <= cy;
                cond.v <= ov;
            end
        end
    end
endmodule

// File: rtl/pfx_decode_front.sv
module pfx_decode_front
    import pfx_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int DATA_W  = 16,
    parameter int NREG    = 16,
    parameter int ROMBUF_REG = 14,
    localparam int SEL_W  = $clog2(NREG),
    localparam int IDX_W  = BYTE_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              pipe_fill,
    input  logic [BYTE_W-1:0] fetch_byte,
    input  logic [2:0]        op_kind,
    input  logic [SEL_W-1:0]  op_reg,
    input  logic [DATA_W-1:0] result,
    input  logic              upd_zs,
    input  logic              upd_cv,
    input  logic              carry_in,
    input  logic              ovf_in,
    input  logic              wr_en,
    output logic [IDX_W-1:0]  dec_index,
    output logic [SEL_W-1:0]  src_sel,
    output logic [SEL_W-1:0]  dst_sel,
    output logic [ST_W-1:0]   status,
    output logic              rom_refresh
);
    op_kind_e          kind;
    logic              plain_step;
    logic [BYTE_W-1:0] pipe_q;
    page_t             page;
    logic              bind_f;
    cond_t             cond;

    assign kind       = op_kind_e'(op_kind);
    assign plain_step = step && is_plain(kind);

    pfx_pipe #(.BYTE_W(BYTE_W)) u_pipe (
        .clk (clk),
        .rst (rst),
        .load(step | pipe_fill),
        .din (fetch_byte),
        .q   (pipe_q)
    );

    pfx_mode #(.SEL_W(SEL_W)) u_mode (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .kind  (kind),
        .reg_in(op_reg),
        .page  (page),
        .bind_f(bind_f),
        .src   (src_sel),
        .dst   (dst_sel)
    );

    pfx_cond #(.DATA_W(DATA_W)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .upd_zs(plain_step & upd_zs),
        .upd_cv(plain_step & upd_cv),
        .res   (result),
        .cy    (carry_in),
        .ov    (ovf_in),
        .cond  (cond)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rom_refresh <= 1'b0;
        else
            rom_refresh <= plain_step && wr_en &&
                           (dst_sel == SEL_W'(ROMBUF_REG));
    end

    assign dec_index = {page.hi, page.lo, pipe_q};

    always_comb begin
        status          = '0;
        status[ST_Z]    = cond.z;
        status[ST_C]    = cond.c;
        status[ST_S]    = cond.s;
        status[ST_V]    = cond.v;
        status[ST_PLO]  = page.lo;
        status[ST_PHI]  = page.hi;
        status[ST_BIND] = bind_f;
    end
endmodule

// File: rtl/pfx_decode_front_chk.sv
module pfx_decode_front_chk #(
    parameter int BYTE_W = 8,
    parameter int DATA_W = 16,
    parameter int SEL_W  = 4,
    parameter int IDX_W  = 10,
    parameter int ROMBUF_REG = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              step,
    input logic              pipe_fill,
    input logic [BYTE_W-1:0] fetch_byte,
    input logic [2:0]        op_kind,
    input logic [SEL_W-1:0]  op_reg,
    input logic [DATA_W-1:0] result,
    input logic              upd_zs,
    input logic              upd_cv,
    input logic              carry_in,
    input logic              ovf_in,
    input logic              wr_en,
    input logic [IDX_W-1:0]  dec_index,
    input logic [SEL_W-1:0]  src_sel,
    input logic [SEL_W-1:0]  dst_sel,
    input logic [15:0]       status,
    input logic              rom_refresh
);
    logic plain;
    assign plain = (op_kind == 3'd0) || (op_kind == 3'd7);

    assert_pipe_load_R2: assert property (@(posedge clk) disable iff (rst)
        step |=> dec_index[BYTE_W-1:0] == $past(fetch_byte));

    assert_page3_index_R3: assert property (@(posedge clk) disable iff (rst)
        (step && op_kind == 3'd3) |=> dec_index[IDX_W-1:IDX_W-2] == 2'b11);

    assert_bind_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (step && op_kind == 3'd6) |=> status[12] && src_sel == $past(op_reg)
                                       && dst_sel == $past(op_reg));

    assert_prefix_keeps_cond_R6: assert property (@(posedge clk) disable iff (rst)
        (step && !plain) |=> $stable(status[4:1]));

    assert_plain_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (step && plain) |=> status[9:8] == 2'b00 && !status[12]
                             && src_sel == '0 && dst_sel == '0);

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (step && plain && upd_zs) |=> status[1] == ($past(result) == '0)
                                       && status[3] == $past(result[DATA_W-1]));

    assert_refresh_cause_R10: assert property (@(posedge clk) disable iff (rst)
        rom_refresh |-> $past(step && plain && wr_en
                              && dst_sel == SEL_W'(ROMBUF_REG)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!step && !pipe_fill) |=> $stable(status) && $stable(dec_index)
                                   && $stable(src_sel) && $stable(dst_sel));
endmodule

bind pfx_decode_front pfx_decode_front_chk #(
    .BYTE_W(BYTE_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .IDX_W(IDX_W),
    .ROMBUF_REG(ROMBUF_REG)
) u_chk (.*);

// File: tb/tb_pfx_decode_front.sv
module tb_pfx_decode_front;
    logic        clk = 1'b0;
    logic        rst;
    logic        step, pipe_fill;
    logic [7:0]  fetch_byte;
    logic [2:0]  op_kind;
    logic [3:0]  op_reg;
    logic [15:0] result;
    logic        upd_zs, upd_cv, carry_in, ovf_in, wr_en;
    logic [9:0]  dec_index;
    logic [3:0]  src_sel, dst_sel;
    logic [15:0] status;
    logic        rom_refresh;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [7:0] m_pipe;
    logic       m_lo, m_hi, m_bind, m_z, m_s, m_c, m_v, m_rom;
    logic [3:0] m_src, m_dst;

    always #4 clk = ~clk;

    pfx_decode_front dut (
        .clk(clk), .rst(rst), .step(step), .pipe_fill(pipe_fill),
        .fetch_byte(fetch_byte), .op_kind(op_kind), .op_reg(op_reg),
        .result(result), .upd_zs(upd_zs), .upd_cv(upd_cv),
        .carry_in(carry_in), .ovf_in(ovf_in), .wr_en(wr_en),
        .dec_index(dec_index), .src_sel(src_sel), .dst_sel(dst_sel),
        .status(status), .rom_refresh(rom_refresh)
    );

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R11: actual cycles=%0d expected <150000", cycles);
            summary_and_end();
        end
    end

    task automatic check(string tag);
        logic [15:0] es;
        logic [9:0]  ei;
        es = '0;
        es[1] = m_z; es[2] = m_c; es[3] = m_s; es[4] = m_v;
        es[8] = m_lo; es[9] = m_hi; es[12] = m_bind;
        ei = {m_hi, m_lo, m_pipe};
        n_chk++;
        if (dec_index !== ei || src_sel !== m_src || dst_sel !== m_dst ||
            status !== es || rom_refresh !== m_rom) begin
            n_bad++;
            $display("FAIL %s: actual idx=%h src=%0d dst=%0d st=%h rr=%b expected idx=%h src=%0d dst=%0d st=%h rr=%b",
                     tag, dec_index, src_sel, dst_sel, status, rom_refresh,
                     ei, m_src, m_dst, es, m_rom);
        end
    endtask

    task automatic idle_inputs();
        step = 0; pipe_fill = 0; fetch_byte = 8'h00; op_kind = 3'd0;
        op_reg = 4'd0; result = 16'h0; upd_zs = 0; upd_cv = 0;
        carry_in = 0; ovf_in = 0; wr_en = 0;
    endtask

    // One execute step; checked at the falling edge after the update.
    task automatic do_step(input logic [2:0] k, input logic [3:0] r,
                           input logic [7:0] b, input logic [15:0] res,
                           input logic ezs, input logic ecv,
                           input logic cy, input logic ov, input logic wr,
                           input string tag);
        step = 1; op_kind = k; op_reg = r; fetch_byte = b; result = res;
        upd_zs = ezs; upd_cv = ecv; carry_in = cy; ovf_in = ov; wr_en = wr;
        @(posedge clk);
        @(negedge clk);
        m_rom = 1'b0;
        case (k)
            3'd1: begin m_lo = 1; m_hi = 0; end
            3'd2: begin m_lo = 0; m_hi = 1; end
            3'd3: begin m_lo = 1; m_hi = 1; end
            3'd4: m_dst = r;
            3'd5: m_src = r;
            3'd6: begin m_bind = 1; m_src = r; m_dst = r; end
            default: begin
                m_rom = wr && (m_dst == 4'd14);
                if (ezs) begin m_z = (res == 16'h0); m_s = res[15]; end
                if (ecv) begin m_c = cy; m_v = ov; end
                m_lo = 0; m_hi = 0; m_bind = 0; m_src = 0; m_dst = 0;
            end
        endcase
        m_pipe = b;
        idle_inputs();
        check(tag);
    endtask

    task automatic plain(input string tag);
        do_step(3'd0, 4'd0, 8'h00, 16'h1, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        m_pipe = 0; m_lo = 0; m_hi = 0; m_bind = 0; m_z = 0; m_s = 0;
        m_c = 0; m_v = 0; m_rom = 0; m_src = 0; m_dst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 reset state");

        // R2: fill-only load, then a full byte sweep through the pipe
        pipe_fill = 1; fetch_byte = 8'hA5;
        @(posedge clk); @(negedge clk);
        idle_inputs(); m_pipe = 8'hA5;
        check("R2 fill loads pipe");
        for (int b = 0; b < 256; b++)
            do_step(3'd0, 4'd0, 8'(b), 16'h1234, 0, 0, 0, 0, 0, "R2 pipe sweep");

        // R3: every page prefix with a spread of opcodes
        for (int p = 1; p < 4; p++) begin
            for (int o = 0; o < 256; o += 17) begin
                do_step(3'(p), 4'd0, 8'(o), 16'h0, 1, 1, 1, 1, 0, "R3 page index");
                plain("R7 clear after page");
            end
        end

        // R4 / R5: every register through dest, source and bind prefixes
        for (int r = 0; r < 16; r++) begin
            do_step(3'd4, 4'(r), 8'h10, 16'h0, 0, 0, 0, 0, 0, "R4 dest select");
            do_step(3'd5, 4'(15 - r), 8'h20, 16'h0, 0, 0, 0, 0, 0, "R4 source select");
            plain("R7 clear pointers");
            do_step(3'd6, 4'(r), 8'h30, 16'h0, 0, 0, 0, 0, 0, "R5 bind prefix");
            do_step(3'd7, 4'd0, 8'h31, 16'h0, 0, 0, 0, 0, 0, "R7 reserved kind clears");
        end

        // R6: stacked prefixes persist; prefixes leave condition bits alone
        do_step(3'd0, 4'd0, 8'h01, 16'h8000, 1, 1, 1, 1, 0, "R8 set cond");
        do_step(3'd4, 4'd5, 8'h02, 16'h0000, 1, 1, 0, 0, 1, "R6 dest kept");
        do_step(3'd2, 4'd0, 8'h03, 16'h0000, 1, 1, 0, 0, 1, "R6 page kept");
        do_step(3'd5, 4'd9, 8'h04, 16'h0000, 1, 1, 0, 0, 1, "R6 source kept");
        do_step(3'd6, 4'd3, 8'h05, 16'h0000, 1, 1, 0, 0, 1, "R6 bind over pointers");
        do_step(3'd1, 4'd0, 8'h06, 16'h0000, 1, 1, 0, 0, 1, "R6 page change keeps bind");
        plain("R7 clear all prefix state");

        // R8: zero and sign from a sweep of results, and hold when disabled
        for (int i = 0; i < 256; i++) begin
            do_step(3'd0, 4'd0, 8'(i), 16'((i * 16'd257) ^ (i << 7)), 1, 0, 0, 0, 0, "R8 zero sign");
            do_step(3'd0, 4'd0, 8'(i), 16'(i), 0, 0, 0, 0, 0, "R8 hold disabled");
        end
        do_step(3'd0, 4'd0, 8'h00, 16'h0000, 1, 0, 0, 0, 0, "R8 exact zero");
        do_step(3'd0, 4'd0, 8'h00, 16'h8000, 1, 0, 0, 0, 0, "R8 sign only");

        // R9: carry and overflow combinations, with and without enable
        for (int c = 0; c < 4; c++) begin
            do_step(3'd0, 4'd0, 8'h40, 16'h1, 0, 1, c[0], c[1], 0, "R9 cv update");
            do_step(3'd0, 4'd0, 8'h41, 16'h1, 0, 0, ~c[0], ~c[1], 0, "R9 cv hold");
        end

        // R10: refresh only for write to register 14 by an ordinary step
        for (int r = 0; r < 16; r++) begin
            do_step(3'd4, 4'(r), 8'h50, 16'h0, 0, 0, 0, 0, 1, "R10 prefix no refresh");
            do_step(3'd0, 4'd0, 8'h51, 16'h0, 0, 0, 0, 0, 1, "R10 refresh on write");
            @(negedge clk); m_rom = 0;
            check("R10 refresh single cycle");
        end
        do_step(3'd4, 4'd14, 8'h52, 16'h0, 0, 0, 0, 0, 0, "R10 dest 14");
        do_step(3'd0, 4'd0, 8'h53, 16'h0, 0, 0, 0, 0, 0, "R10 no write no refresh");

        // R11: idle cycles with noisy inputs change nothing
        do_step(3'd3, 4'd0, 8'h60, 16'h0, 0, 0, 0, 0, 0, "R11 setup page");
        do_step(3'd6, 4'd14, 8'h61, 16'h0, 0, 0, 0, 0, 0, "R11 setup bind");
        for (int i = 0; i < 16; i++) begin
            op_kind = 3'(i); op_reg = 4'(i); fetch_byte = 8'(i * 11);
            result = 16'h0; upd_zs = 1; upd_cv = 1; carry_in = 1; ovf_in = 1;
            wr_en = 1;
            @(posedge clk); @(negedge clk);
            check("R11 idle hold");
        end
        idle_inputs();
        summary_and_end();
    end
endmodule